// File: doc/BRIEF.md
# Packet Page Allocation Unit

This unit tracks a small pool of fixed-size packet pages for a network controller. One bitmap records which pages are taken. Three ordered queues of page numbers share that bitmap:

- a transmit queue, which feeds a transmitter;
- a completion queue, which holds pages whose transmission has finished;
- a receive queue, which holds pages filled by a frame writer.

A host drives the unit through a 3-bit command code (the top three bits of its command byte, extracted by the bus decoder) and a packet-number value. With these it can allocate, release, enqueue, pop and clear. The host reads back the allocation result, the head of each queue, the number of pages in use and an interrupt status byte with mask and acknowledge.

Pages are requested from two sides. The frame writer raises a receive request and is answered combinationally in the same cycle with a grant and a page number. The host issues transmit allocations. A transmit allocation that finds no free page leaves the failure code 0x80 as its result and stays pending. Any later release of a page retries it automatically in the cycle of that release.

Outputs that report a page number use an 8-bit byte: the page index zero-extended, or 0x80 for "none". Interrupt bits are: bit 0 receive, bit 1 transmit complete, bit 2 transmit queue empty, bit 3 allocation done, bits 4–7 reserved status (never set by this unit).

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the allocation result reads 0, all three queue heads read 0x80, no pages are in use, the status byte reads 0x04, the mask reads 0 and `irq` is low.
- R2: Command code 1 allocates the lowest-numbered free page and stores its number as the result, and it sets status bit 3. When no page is free, the result becomes 0x80 and status bit 3 is cleared.
- R3: While the result is 0x80, any cycle that releases a page retries the allocation in that same cycle. A successful retry stores the page and sets status bit 3.
- R4: A receive request is granted with the lowest free page when one exists and the receive queue is not full. The page is marked used, appended to the receive queue, and status bit 0 is set. If a transmit allocation happens in the same cycle, the receive side picks first and the transmit side takes the lowest page left over.
- R5: Command 3 pops the receive queue. Command 4 pops it and frees its head page. After either, status bit 0 is set if entries remain and cleared if the queue is empty. An empty receive head reads 0x80.
- R6: Command 5 frees the page named by the packet-number input.
- R7: Command 6 appends the packet-number page to the transmit queue. The append is ignored when the queue already holds as many entries as there are pages. An empty transmit head reads 0x80.
- R8: A transmit-done pulse removes the transmit head. With auto-release high, that page is freed. Otherwise it is appended to the completion queue if there is room. The completion head reads 0x80 when the queue is empty.
- R9: An acknowledge clears only the status bits set in both its value and 0xD6. If the acknowledge has bit 1 set, it also pops one completion entry.
- R10: Status bit 2 is set in every cycle that ends with an empty transmit queue. Status bit 1 is set in every cycle that ends with a non-empty completion queue. Both are set even right after an acknowledge.
- R11: A mask write loads the mask byte. `irq` is high exactly when status ANDed with mask is non-zero.
- R12: Command 2 frees every page, empties all three queues, sets the result to 0 and refuses a receive request in the same cycle. Command 7 empties the transmit and completion queues only.
- R13: The used-page count equals the number of pages marked used.
- R14: Command 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (top three bits of the host command byte) |
| pnum | input | PW | Packet-number value used by release and enqueue |
| auto_release | input | 1 | Free transmitted pages instead of queuing them for completion |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_valid | input | 1 | Mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| rx_req | input | 1 | Receive page request from the frame writer |
| rx_ok | output | 1 | Receive request granted this cycle |
| rx_page | output | PW | Page granted to the receive request |
| txd_valid | input | 1 | Transmit of the head page finished |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| alloc_result | output | 8 | Last transmit allocation result |
| used_pages | output | CW | Number of pages in use |
| irq_status | output | 8 | Interrupt status byte |
| irq_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt request |

## Verification
Several functions can land on the page bitmap in the same cycle. A receive request may arrive together with a transmit allocation, whether that allocation comes from command 1 or from a retry triggered by a release or an auto-release. A directed case issues a receive request and an allocate command in the same cycle and expects the receive grant to take the lowest page and the transmit result the next one. A long random sweep then drives commands, transmit-done pulses, acknowledges and receive requests together. Every cycle it compares the grant, the heads, the result, the count and the status against an arithmetic model that resolves each cycle in the order the requirements give.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_TXALLOC = 3'd1,
    OP_RESET   = 3'd2,
    OP_RXPOP   = 3'd3,
    OP_RXFREE  = 3'd4,
    OP_RELEASE = 3'd5,
    OP_TXPUSH  = 3'd6,
    OP_TXCLR   = 3'd7
  } mmu_op_e;

  localparam logic [7:0] NO_PAGE  = 8'h80;
  localparam logic [7:0] ACK_MASK = 8'hD6;
  localparam logic [7:0] STAT_RST = 8'h04;

  localparam int IRQ_RX    = 0;
  localparam int IRQ_TX    = 1;
  localparam int IRQ_TXE   = 2;
  localparam int IRQ_ALLOC = 3;

endpackage

// File: rtl/page_pick.sv
// Lowest-index set bit finder.
module page_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] free_vec,
  output logic         found,
  output logic [W-1:0] idx,
  output logic [N-1:0] onehot
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_oh
      assign onehot[g] = found && (idx == W'(g));
    end
  endgenerate

endmodule

// File: rtl/page_queue.sv
// Shift-down ordered queue of page numbers.
module page_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, wr_idx;
  logic          take, put;

  assign take   = pop && (cnt_q != '0);
  assign put    = push && ((cnt_q < CW'(DEPTH)) || take);
  assign wr_idx = cnt_q - CW'(take);

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      if (take) begin
        for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
      end
      if (put) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == wr_idx) mem_d[i] = din;
        end
      end
      cnt_d = cnt_q - CW'(take) + CW'(put);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[g] <= '0;
        else        mem_q[g] <= mem_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign head     = mem_q[0];
  assign count    = cnt_q;
  assign count_nx = cnt_d;

  // R7: a queue never holds more entries than its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: a push into a full queue with no pop is dropped
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push && !pop && !clr) |=> cnt_q == CW'(DEPTH));

endmodule

// File: rtl/pkt_irq_regs.sv
// Interrupt status, mask and request.
module pkt_irq_regs
  import pkt_page_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_valid,
  input  logic [7:0] ack_byte,
  input  logic       mask_valid,
  input  logic [7:0] mask_byte,
  input  logic       alloc_clr,
  input  logic       alloc_set,
  input  logic       rx_set,
  input  logic       rx_clr,
  input  logic       txe_set,
  input  logic       tx_set,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);

  logic [7:0] stat_q, stat_d, mask_q;

  always_comb begin
    stat_d = stat_q;
    if (ack_valid) stat_d = stat_d & ~(ack_byte & ACK_MASK);
    if (alloc_clr) stat_d[IRQ_ALLOC] = 1'b0;
    if (alloc_set) stat_d[IRQ_ALLOC] = 1'b1;
    if (rx_clr)    stat_d[IRQ_RX]    = 1'b0;
    if (rx_set)    stat_d[IRQ_RX]    = 1'b1;
    if (txe_set)   stat_d[IRQ_TXE]   = 1'b1;
    if (tx_set)    stat_d[IRQ_TX]    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '0;
    else if (mask_valid) mask_q <= mask_byte;
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);

  // R9: an acknowledge never clears the receive bit
  a_r9_ack_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && stat_q[IRQ_RX] && !rx_clr) |=> stat_q[IRQ_RX]);

  // R11: a mask write lands on the next cycle
  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |=> mask_q == $past(mask_byte));

endmodule

// File: rtl/pkt_page_mgr.sv
// Packet page allocation unit: bitmap, three queues, host commands.
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int  NPAGES = 4,
  localparam int PW     = (NPAGES > 1) ? $clog2(NPAGES) : 1,
  localparam int CW     = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [PW-1:0] pnum,
  input  logic          auto_release,
  input  logic          ack_valid,
  input  logic [7:0]    ack_byte,
  input  logic          mask_valid,
  input  logic [7:0]    mask_byte,
  input  logic          rx_req,
  output logic          rx_ok,
  output logic [PW-1:0] rx_page,
  input  logic          txd_valid,
  output logic [7:0]    tx_head,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [7:0]    alloc_result,
  output logic [CW-1:0] used_pages,
  output logic [7:0]    irq_status,
  output logic [7:0]    irq_mask,
  output logic          irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // command decode
  mmu_op_e op;
  logic do_alloc, do_reset, do_rxpop, do_rxfree, do_release, do_txpush, do_txclr;

  assign op         = mmu_op_e'(cmd_code);
  assign do_alloc   = cmd_valid && (op == OP_TXALLOC);
  assign do_reset   = cmd_valid && (op == OP_RESET);
  assign do_rxpop   = cmd_valid && (op == OP_RXPOP);
  assign do_rxfree  = cmd_valid && (op == OP_RXFREE);
  assign do_release = cmd_valid && (op == OP_RELEASE);
  assign do_txpush  = cmd_valid && (op == OP_TXPUSH);
  assign do_txclr   = cmd_valid && (op == OP_TXCLR);

  // state
  logic [NPAGES-1:0] bitmap_q, bitmap_d;
  logic [7:0]        alloc_q, alloc_d;
  logic              alloc_en;

  // queues
  logic [PW-1:0] txq_head, doneq_head, rxq_head;
  logic [CW-1:0] txq_cnt, txq_cnt_nx, doneq_cnt, doneq_cnt_nx, rxq_cnt, rxq_cnt_nx;
  logic          txq_clr, tx_fire, done_push, done_pop, rx_pop_any;

  assign txq_clr    = do_reset || do_txclr;
  assign tx_fire    = txd_valid && !txq_clr && (txq_cnt != '0);
  assign done_push  = tx_fire && !auto_release;
  assign done_pop   = ack_valid && ack_byte[IRQ_TX];
  assign rx_pop_any = do_rxpop || do_rxfree;

  // page picking
  logic [NPAGES-1:0] rel_vec, avail, tx_avail, rx_oh, tx_oh, rx_pick_oh, tx_pick_oh;
  logic              rx_found, tx_found, tx_try, tx_ok, alloc_pending;
  logic [PW-1:0]     rx_idx, tx_idx;

  always_comb begin
    rel_vec = '0;
    if (do_rxfree && (rxq_cnt != '0)) rel_vec = rel_vec | (NPAGES'(1) << rxq_head);
    if (do_release)                   rel_vec = rel_vec | (NPAGES'(1) << pnum);
    if (tx_fire && auto_release)      rel_vec = rel_vec | (NPAGES'(1) << txq_head);
  end

  assign avail = ~bitmap_q | rel_vec;

  page_pick #(.N(NPAGES), .W(PW)) u_rx_pick (
    .free_vec (avail),
    .found    (rx_found),
    .idx      (rx_idx),
    .onehot   (rx_pick_oh)
  );

  assign rx_ok    = rx_req && !do_reset && rx_found && (rxq_cnt < CW'(NPAGES));
  assign rx_page  = rx_idx;
  assign rx_oh    = rx_ok ? rx_pick_oh : '0;
  assign tx_avail = avail & ~rx_oh;

  page_pick #(.N(NPAGES), .W(PW)) u_tx_pick (
    .free_vec (tx_avail),
    .found    (tx_found),
    .idx      (tx_idx),
    .onehot   (tx_pick_oh)
  );

  assign alloc_pending = (alloc_q == NO_PAGE);
  assign tx_try        = !do_reset && (do_alloc || (alloc_pending && (rel_vec != '0)));
  assign tx_ok         = tx_try && tx_found;
  assign tx_oh         = tx_ok ? tx_pick_oh : '0;

  // next state
  always_comb begin
    if (do_reset) bitmap_d = '0;
    else          bitmap_d = (bitmap_q & ~rel_vec) | rx_oh | tx_oh;
  end

  assign alloc_en = do_reset || tx_ok || do_alloc;

  always_comb begin
    if (do_reset)   alloc_d = 8'h00;
    else if (tx_ok) alloc_d = {{(8-PW){1'b0}}, tx_idx};
    else            alloc_d = NO_PAGE;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) bitmap_q <= '0;
    else         bitmap_q <= bitmap_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       alloc_q <= 8'h00;
    else if (alloc_en) alloc_q <= alloc_d;
  end

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_txq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (txq_clr),
    .push     (do_txpush),
    .din      (pnum),
    .pop      (tx_fire),
    .head     (txq_head),
    .count    (txq_cnt),
    .count_nx (txq_cnt_nx)
  );

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_doneq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (txq_clr),
    .push     (done_push),
    .din      (txq_head),
    .pop      (done_pop),
    .head     (doneq_head),
    .count    (doneq_cnt),
    .count_nx (doneq_cnt_nx)
  );

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (do_reset),
    .push     (rx_ok),
    .din      (rx_idx),
    .pop      (rx_pop_any),
    .head     (rxq_head),
    .count    (rxq_cnt),
    .count_nx (rxq_cnt_nx)
  );

  pkt_irq_regs u_irq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ack_valid  (ack_valid),
    .ack_byte   (ack_byte),
    .mask_valid (mask_valid),
    .mask_byte  (mask_byte),
    .alloc_clr  (do_alloc),
    .alloc_set  (tx_ok),
    .rx_set     (rx_ok || (rx_pop_any && (rxq_cnt_nx != '0))),
    .rx_clr     (rx_pop_any && (rxq_cnt_nx == '0)),
    .txe_set    (txq_cnt_nx == '0),
    .tx_set     (doneq_cnt_nx != '0),
    .status     (irq_status),
    .mask       (irq_mask),
    .irq        (irq)
  );

  // outputs
  assign tx_head      = (txq_cnt   == '0) ? NO_PAGE : {{(8-PW){1'b0}}, txq_head};
  assign done_head    = (doneq_cnt == '0) ? NO_PAGE : {{(8-PW){1'b0}}, doneq_head};
  assign rx_head      = (rxq_cnt   == '0) ? NO_PAGE : {{(8-PW){1'b0}}, rxq_head};
  assign alloc_result = alloc_q;
  assign used_pages   = CW'($countones(bitmap_q));

  // R2: with every page used and nothing freed, an allocation fails
  a_r2_full_fails: assert property (@(posedge clk) disable iff (!rst_sn)
    (do_alloc && (&bitmap_q) && (rel_vec == '0)) |=> alloc_q == NO_PAGE);

  // R3: a release of a used page while pending satisfies the allocation
  a_r3_retry: assert property (@(posedge clk) disable iff (!rst_sn)
    (alloc_pending && do_release && bitmap_q[pnum] && !rx_req) |=> alloc_q != NO_PAGE);

  // R4: the receive side picks below the transmit side in a shared cycle
  a_r4_rx_first: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_ok && tx_ok) |-> (rx_idx < tx_idx));

  // R12: unit reset empties the bitmap and the receive queue
  a_r12_unit_reset: assert property (@(posedge clk) disable iff (!rst_sn)
    do_reset |=> (bitmap_q == '0 && rxq_cnt == '0));

  // R10: empty transmit queue implies the empty bit
  a_r10_tx_empty: assert property (@(posedge clk) disable iff (!rst_sn)
    (txq_cnt == '0) |-> irq_status[IRQ_TXE]);

  // R10: pending completions imply the transmit bit
  a_r10_tx_done: assert property (@(posedge clk) disable iff (!rst_sn)
    (doneq_cnt != '0) |-> irq_status[IRQ_TX]);

endmodule

// File: tb/pkt_page_mgr_tb.sv
module pkt_page_mgr_tb;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_code;
  logic [PW-1:0] pnum;
  logic          auto_release, ack_valid, mask_valid, rx_req, txd_valid;
  logic [7:0]    ack_byte, mask_byte;
  logic          rx_ok, irq;
  logic [PW-1:0] rx_page;
  logic [7:0]    tx_head, done_head, rx_head, alloc_result, irq_status, irq_mask;
  logic [CW-1:0] used_pages;

  pkt_page_mgr #(.NPAGES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pnum(pnum), .auto_release(auto_release), .ack_valid(ack_valid),
    .ack_byte(ack_byte), .mask_valid(mask_valid), .mask_byte(mask_byte),
    .rx_req(rx_req), .rx_ok(rx_ok), .rx_page(rx_page), .txd_valid(txd_valid),
    .tx_head(tx_head), .done_head(done_head), .rx_head(rx_head),
    .alloc_result(alloc_result), .used_pages(used_pages),
    .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq)
  );

  int errs = 0;
  int checks = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model
  logic [N-1:0] m_bm;
  int           m_alloc;
  int           m_txq[$];
  int           m_dq[$];
  int           m_rxq[$];
  logic [7:0]   m_st, m_mask;

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int headval(int q[$]);
    return (q.size() == 0) ? 'h80 : q[0];
  endfunction

  task automatic idle();
    cmd_valid = 0; cmd_code = 0; pnum = 0; auto_release = 0;
    ack_valid = 0; ack_byte = 0; mask_valid = 0; mask_byte = 0;
    rx_req = 0; txd_valid = 0;
  endtask

  task automatic compare_all();
    chk("R2 alloc_result", int'(alloc_result), m_alloc);
    chk("R7 tx_head", int'(tx_head), headval(m_txq));
    chk("R8 done_head", int'(done_head), headval(m_dq));
    chk("R5 rx_head", int'(rx_head), headval(m_rxq));
    chk("R13 used_pages", int'(used_pages), $countones(m_bm));
    chk("R10 irq_status", int'(irq_status), int'(m_st));
    chk("R11 irq_mask", int'(irq_mask), int'(m_mask));
    chk("R11 irq", int'(irq), int'(|(m_st & m_mask)));
  endtask

  // one clock: inputs already set; checks grant before the edge, state after
  task automatic tick();
    int op, rp, tp, page;
    logic [N-1:0] rel, av, av2;
    bit rxok, txok, fire, rst_u, clr_t, try_t;
    @(negedge clk);
    op    = cmd_valid ? int'(cmd_code) : -1;
    rst_u = (op == 2);
    clr_t = rst_u || (op == 7);
    rel   = '0;
    if (op == 4 && m_rxq.size() > 0) rel[m_rxq[0]] = 1'b1;
    if (op == 5) rel[pnum] = 1'b1;
    fire = txd_valid && !clr_t && (m_txq.size() > 0);
    page = fire ? m_txq[0] : 0;
    if (fire && auto_release) rel[page] = 1'b1;
    av   = ~m_bm | rel;
    rp   = lowest(av);
    rxok = rx_req && !rst_u && (rp >= 0) && (m_rxq.size() < N);
    chk("R4 rx grant", int'(rx_ok), int'(rxok));
    if (rxok) chk("R4 rx page lowest", int'(rx_page), rp);
    av2 = av;
    if (rxok) av2[rp] = 1'b0;
    tp    = lowest(av2);
    try_t = !rst_u && ((op == 1) || (m_alloc == 'h80 && rel != '0));
    txok  = try_t && (tp >= 0);
    @(posedge clk);
    #1;
    if (rst_u) begin
      m_bm = '0; m_alloc = 0;
      m_txq.delete(); m_dq.delete(); m_rxq.delete();
    end else begin
      m_bm = m_bm & ~rel;
      if (rxok) m_bm[rp] = 1'b1;
      if (txok) m_bm[tp] = 1'b1;
      if (txok) m_alloc = tp;
      else if (op == 1) m_alloc = 'h80;
      if ((op == 3 || op == 4) && m_rxq.size() > 0) void'(m_rxq.pop_front());
      if (rxok) m_rxq.push_back(rp);
      if (clr_t) begin
        m_txq.delete(); m_dq.delete();
      end else begin
        if (fire) void'(m_txq.pop_front());
        if (op == 6 && m_txq.size() < N) m_txq.push_back(int'(pnum));
        if (ack_valid && ack_byte[1] && m_dq.size() > 0) void'(m_dq.pop_front());
        if (fire && !auto_release && m_dq.size() < N) m_dq.push_back(page);
      end
    end
    if (ack_valid) m_st = m_st & ~(ack_byte & 8'hD6);
    if (op == 1) m_st[3] = 1'b0;
    if (txok) m_st[3] = 1'b1;
    if (op == 3 || op == 4) m_st[0] = (m_rxq.size() != 0);
    if (rxok) m_st[0] = 1'b1;
    if (m_txq.size() == 0) m_st[2] = 1'b1;
    if (m_dq.size() != 0) m_st[1] = 1'b1;
    if (mask_valid) m_mask = mask_byte;
    compare_all();
    idle();
  endtask

  task automatic cmd(int code, int pn);
    cmd_valid = 1; cmd_code = 3'(code); pnum = PW'(pn);
    tick();
  endtask

  task automatic ack(int v);
    ack_valid = 1; ack_byte = 8'(v);
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    m_bm = '0; m_alloc = 0; m_st = 8'h04; m_mask = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 alloc_result", int'(alloc_result), 0);
    chk("R1 tx_head", int'(tx_head), 'h80);
    chk("R1 done_head", int'(done_head), 'h80);
    chk("R1 rx_head", int'(rx_head), 'h80);
    chk("R1 used", int'(used_pages), 0);
    chk("R1 status", int'(irq_status), 'h04);
    chk("R1 mask", int'(irq_mask), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 lowest free first, then failure
    for (int k = 0; k < N; k++) begin
      cmd(1, 0);
      chk("R2 lowest free page", int'(alloc_result), k);
    end
    cmd(1, 0);
    chk("R2 full gives 0x80", int'(alloc_result), 'h80);
    chk("R2 alloc bit cleared", int'(irq_status[3]), 0);

    // R6 release plus R3 retry in the same cycle
    cmd(5, 2);
    chk("R3 retry takes freed page", int'(alloc_result), 2);
    chk("R3 alloc bit set", int'(irq_status[3]), 1);
    chk("R6 used after release+retry", int'(used_pages), 4);

    // R14 no-op
    cmd(0, 1);
    chk("R14 result unchanged", int'(alloc_result), 2);
    chk("R14 used unchanged", int'(used_pages), 4);

    // R12 unit reset
    cmd(2, 0);
    chk("R12 pages freed", int'(used_pages), 0);
    chk("R12 result zero", int'(alloc_result), 0);

    // R4 receive and transmit allocation in one cycle
    cmd(1, 0);
    rx_req = 1;
    cmd(1, 0);
    chk("R4 rx took page 1", int'(rx_head), 1);
    chk("R4 tx took page 2", int'(alloc_result), 2);

    // R7 enqueue
    cmd(6, 2);
    chk("R7 tx head", int'(tx_head), 2);
    cmd(6, 0);
    chk("R7 head keeps oldest", int'(tx_head), 2);

    // R9 acknowledge mask: bits 0 and 3 survive, bit 2 cleared
    ack('hFF);
    chk("R9 ack masked by 0xD6", int'(irq_status), 'h09);

    // R8 completion without auto-release
    txd_valid = 1;
    tick();
    chk("R8 done head", int'(done_head), 2);
    chk("R10 tx bit set", int'(irq_status), 'h0B);

    // R8 auto-release
    txd_valid = 1; auto_release = 1;
    tick();
    chk("R8 auto-release frees page", int'(used_pages), 2);
    chk("R10 empty bit set", int'(irq_status), 'h0F);

    // R9 acknowledge pops completion
    ack('h02);
    chk("R9 done popped", int'(done_head), 'h80);
    chk("R9 tx bit cleared", int'(irq_status), 'h0D);

    // R11 mask
    mask_valid = 1; mask_byte = 8'h02;
    tick();
    chk("R11 masked off", int'(irq), 0);
    mask_valid = 1; mask_byte = 8'h01;
    tick();
    chk("R11 masked on", int'(irq), 1);

    // R5 pop and free the receive head
    cmd(4, 0);
    chk("R5 rx empty", int'(rx_head), 'h80);
    chk("R5 rx bit cleared", int'(irq_status[0]), 0);
    chk("R5 page freed", int'(used_pages), 1);
    chk("R11 irq dropped", int'(irq), 0);

    // R7 full queue ignores extra push
    for (int k = 0; k < N; k++) cmd(6, k);
    cmd(6, 3);
    for (int k = 0; k < N; k++) begin
      txd_valid = 1;
      tick();
    end
    chk("R7 fifth push dropped", int'(tx_head), 'h80);
    chk("R8 done head oldest", int'(done_head), 0);

    // R12 transmit clear
    cmd(6, 1);
    cmd(7, 0);
    chk("R12 tx cleared", int'(tx_head), 'h80);
    chk("R12 done cleared", int'(done_head), 'h80);

    // random sweep against the model
    for (int n = 0; n < 3000; n++) begin
      int c;
      if ($urandom_range(1, 0) == 1) begin
        c = int'($urandom_range(7, 0));
        if (c == 2 && $urandom_range(7, 0) != 0) c = 1;
        cmd_valid = 1; cmd_code = 3'(c); pnum = PW'($urandom_range(N - 1, 0));
      end
      auto_release = 1'($urandom_range(1, 0));
      txd_valid    = ($urandom_range(9, 0) < 3);
      rx_req       = ($urandom_range(9, 0) < 3);
      if ($urandom_range(9, 0) < 2) begin
        ack_valid = 1; ack_byte = 8'($urandom_range(255, 0));
      end
      if ($urandom_range(9, 0) == 0) begin
        mask_valid = 1; mask_byte = 8'($urandom_range(255, 0));
      end
      tick();
    end
    finish_run();
  end

endmodule